// File: doc/BRIEF.md
# Relative Branch Resolution Unit

This block resolves a two-byte relative conditional branch of an 8-bit processor. Given the 16-bit address of the branch opcode, the signed displacement byte, the outcome of the condition test and a mode select, it produces the next program counter. It also reports the clock cycles the branch costs and whether the taken target lies on a different 256-byte page than the instruction that follows the branch.

The displacement is measured from the byte after the branch, which is the opcode address plus two. A one-cycle start pulse latches a request. One clock later the block raises a done strobe for one cycle, and the registered results are valid at that point. In compatibility mode a taken branch that crosses a page costs one extra cycle. In native mode it does not.

Top module: `rel_branch_unit`

## Requirements
- R1: An active-high synchronous reset clears `done_o`, `next_pc_o`, `cycles_o` and `page_cross_o` to zero.
- R2: `done_o` goes high for exactly one cycle, in the cycle after a cycle in which `start_i` was high. The outputs keep their values until the next request is completed.
- R3: When a branch is not taken, `next_pc_o` equals `op_addr_i + 2`, `cycles_o` is 2 and `page_cross_o` is 0, whatever the displacement.
- R4: When a branch is taken, `next_pc_o` equals `op_addr_i + 2` plus `disp_i`, with `disp_i` sign-extended as an 8-bit two's-complement value. A value with bit 7 set moves backward, so the reach is -128 to +127 bytes.
- R5: A taken branch with displacement 0x00 yields `op_addr_i + 2`. With displacement 0xFE it yields `op_addr_i` itself. Opcode 0x08B8 with displacement 0xFC yields 0x08B6.
- R6: For a taken branch, `page_cross_o` is 1 exactly when bits [15:8] of the target differ from bits [15:8] of `op_addr_i + 2`.
- R7: A taken branch costs 3 cycles, except in compatibility mode (`native_i` = 0) with a page cross, where it costs 4.
- R8: In native mode (`native_i` = 1), a taken branch that crosses a page still costs 3 cycles.
- R9: All address arithmetic wraps modulo 65536, both for the fall-through address and for the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe; the inputs below are sampled with it |
| op_addr_i | input | 16 | Address of the branch opcode byte |
| disp_i | input | 8 | Signed displacement byte |
| taken_i | input | 1 | Condition outcome, 1 = branch taken |
| native_i | input | 1 | 1 = native timing, 0 = compatibility timing |
| done_o | output | 1 | One-cycle result strobe |
| next_pc_o | output | 16 | Resolved program counter |
| cycles_o | output | 3 | Clock cycles the branch consumes |
| page_cross_o | output | 1 | Taken target lies on another page than the fall-through |

## Verification
The hardest cases sit at the edges of the address space. One is a branch whose fall-through address itself wraps, such as an opcode at 0xFFFE or 0xFFFF. The other is a target that wraps past 0x0000 or 0xFFFF while the page compare must still see a cross. The stimulus places opcodes at these extreme addresses with extreme displacements. It then repeats the same page-crossing requests under both timing modes, so that the cycle count is the only output that differs between the two runs.

// File: rtl/rel_branch_pkg.sv
package rel_branch_pkg;

    parameter int ADDR_W  = 16;
    parameter int DISP_W  = 8;
    parameter int PAGE_W  = 8;
    parameter int CYC_W   = 3;
    parameter int INSN_LEN = 2;

    localparam int PAGE_HI = ADDR_W - 1;
    localparam int PAGE_LO = PAGE_W;

    localparam logic [CYC_W-1:0] CYC_NOT_TAKEN = CYC_W'(2);
    localparam logic [CYC_W-1:0] CYC_TAKEN     = CYC_W'(3);
    localparam logic [CYC_W-1:0] CYC_PENALTY   = CYC_W'(1);

    typedef enum logic {
        TIMING_COMPAT = 1'b0,
        TIMING_NATIVE = 1'b1
    } timing_e;

    typedef struct packed {
        logic [ADDR_W-1:0] op_addr;
        logic [DISP_W-1:0] disp;
        logic              taken;
        timing_e           timing;
    } br_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] next_pc;
        logic [CYC_W-1:0]  cycles;
        logic              page_cross;
    } br_res_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic same_page(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return a[PAGE_HI:PAGE_LO] == b[PAGE_HI:PAGE_LO];
    endfunction

endpackage

// File: rtl/rb_target_calc.sv
module rb_target_calc
    import rel_branch_pkg::*;
(
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] fall_o,
    output logic [ADDR_W-1:0] target_o
);
    always_comb begin
        fall_o   = op_addr_i + ADDR_W'(INSN_LEN);
        target_o = fall_o + sext_disp(disp_i);
    end
endmodule

// File: rtl/rb_cycle_acct.sv
module rb_cycle_acct
    import rel_branch_pkg::*;
(
    input  logic [ADDR_W-1:0] fall_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              taken_i,
    input  timing_e           timing_i,
    output br_res_t           res_o
);
    logic crossed;

    always_comb begin
        crossed = taken_i && !same_page(fall_i, target_i);
        res_o.page_cross = crossed;
        res_o.next_pc    = taken_i ? target_i : fall_i;
        if (!taken_i)
            res_o.cycles = CYC_NOT_TAKEN;
        else if (crossed && timing_i == TIMING_COMPAT)
            res_o.cycles = CYC_TAKEN + CYC_PENALTY;
        else
            res_o.cycles = CYC_TAKEN;
    end

    // R8: native timing never adds a cycle
    always_comb begin
        if (taken_i && timing_i == TIMING_NATIVE)
            a_r8_native_flat: assert (res_o.cycles == CYC_TAKEN);
    end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
    import rel_branch_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [15:0]       op_addr_i,
    input  logic [7:0]        disp_i,
    input  logic              taken_i,
    input  logic              native_i,
    output logic              done_o,
    output logic [15:0]       next_pc_o,
    output logic [2:0]        cycles_o,
    output logic              page_cross_o
);
    br_req_t           req;
    logic [ADDR_W-1:0] fall, target;
    br_res_t           res_d, res_q;
    logic              done_q;

    always_comb begin
        req.op_addr = op_addr_i;
        req.disp    = disp_i;
        req.taken   = taken_i;
        req.timing  = native_i ? TIMING_NATIVE : TIMING_COMPAT;
    end

    rb_target_calc u_calc (
        .op_addr_i (req.op_addr),
        .disp_i    (req.disp),
        .fall_o    (fall),
        .target_o  (target)
    );

    rb_cycle_acct u_acct (
        .fall_i   (fall),
        .target_i (target),
        .taken_i  (req.taken),
        .timing_i (req.timing),
        .res_o    (res_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= start_i;
            if (start_i) res_q <= res_d;
        end
    end

    assign done_o       = done_q;
    assign next_pc_o    = res_q.next_pc;
    assign cycles_o     = res_q.cycles;
    assign page_cross_o = res_q.page_cross;

    // R2: done follows start by one cycle
    a_r2_done_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> done_o);
    // R2: outputs hold without a request
    a_r2_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> $stable(next_pc_o) && $stable(cycles_o));
    // R3: not-taken result is fall-through, 2 cycles, no cross
    a_r3_not_taken: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i && !taken_i |=> next_pc_o == $past(op_addr_i) + 16'd2
                                && cycles_o == 3'd2 && !page_cross_o);
    // R6: cross flag only on taken branches
    a_r6_cross_taken: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i && !taken_i |=> !page_cross_o);
    // R7: cycle count stays within 2..4
    a_r7_cycle_range: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> cycles_o >= 3'd2 && cycles_o <= 3'd4);
endmodule

// File: tb/rel_branch_unit_tb_top.sv
`timescale 1ns/1ps
module rel_branch_unit_tb_top;
    logic clk = 1'b0;
    logic rst, start, taken, native;
    logic [15:0] op_addr;
    logic [7:0]  disp;
    logic done, pc_cross;
    logic [15:0] next_pc;
    logic [2:0]  cycles;
    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    rel_branch_unit dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .op_addr_i(op_addr),
        .disp_i(disp), .taken_i(taken), .native_i(native),
        .done_o(done), .next_pc_o(next_pc), .cycles_o(cycles),
        .page_cross_o(pc_cross)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] a, input logic [7:0] d,
                         input logic t, input logic n);
        @(negedge clk);
        op_addr = a; disp = d; taken = t; native = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_branch(input string req, input logic [15:0] a, input logic [7:0] d,
                              input logic t, input logic n);
        logic [15:0] fall, tgt, exp_pc;
        logic        cr;
        logic [2:0]  cy;
        fall = a + 16'd2;
        tgt  = fall + {{8{d[7]}}, d};
        cr   = t && (fall[15:8] != tgt[15:8]);
        exp_pc = t ? tgt : fall;
        cy   = !t ? 3'd2 : (cr && !n) ? 3'd4 : 3'd3;
        issue(a, d, t, n);
        chk({req, " done"}, {31'd0, done}, 32'd1);
        chk({req, " pc"}, {16'd0, next_pc}, {16'd0, exp_pc});
        chk({req, " cycles"}, {29'd0, cycles}, {29'd0, cy});
        chk({req, " cross"}, {31'd0, pc_cross}, {31'd0, cr});
    endtask

    task automatic t_reset;
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 pc", {16'd0, next_pc}, 0);
        chk("R1 cycles", {29'd0, cycles}, 0);
        chk("R1 cross", {31'd0, pc_cross}, 0);
    endtask

    task automatic t_strobe;
        run_branch("R2", 16'h1234, 8'h10, 1'b1, 1'b0);
        @(negedge clk);
        chk("R2 done low", {31'd0, done}, 0);
        chk("R2 hold pc", {16'd0, next_pc}, 32'h1246);
    endtask

    task automatic t_not_taken;
        run_branch("R3 nt fwd", 16'h2000, 8'h7F, 1'b0, 1'b0);
        run_branch("R3 nt back", 16'h2000, 8'h80, 1'b0, 1'b1);
        run_branch("R3 nt page", 16'h20FE, 8'h05, 1'b0, 1'b0);
    endtask

    task automatic t_targets;
        run_branch("R4 max fwd", 16'h3000, 8'h7F, 1'b1, 1'b0);
        run_branch("R4 max back", 16'h3080, 8'h80, 1'b1, 1'b0);
        run_branch("R5 zero", 16'h4444, 8'h00, 1'b1, 1'b0);
        run_branch("R5 self", 16'h4444, 8'hFE, 1'b1, 1'b0);
        run_branch("R5 known", 16'h08B8, 8'hFC, 1'b1, 1'b0);
        chk("R5 known pc", {16'd0, next_pc}, 32'h08B6);
    endtask

    task automatic t_cross;
        run_branch("R6 R7 fwd cross", 16'h10F0, 8'h20, 1'b1, 1'b0);
        chk("R7 four", {29'd0, cycles}, 4);
        run_branch("R6 back cross", 16'h1000, 8'hF0, 1'b1, 1'b0);
        run_branch("R6 edge nocross", 16'h10FB, 8'h02, 1'b1, 1'b0);
        run_branch("R8 native fwd", 16'h10F0, 8'h20, 1'b1, 1'b1);
        chk("R8 three", {29'd0, cycles}, 3);
        run_branch("R8 native back", 16'h1000, 8'hF0, 1'b1, 1'b1);
    endtask

    task automatic t_wrap;
        run_branch("R9 fall wrap", 16'hFFFF, 8'h00, 1'b0, 1'b0);
        chk("R9 fall pc", {16'd0, next_pc}, 32'h0001);
        run_branch("R9 fwd wrap", 16'hFFF0, 8'h7F, 1'b1, 1'b0);
        run_branch("R9 back wrap", 16'h0002, 8'h80, 1'b1, 1'b1);
        run_branch("R9 top wrap", 16'hFFFE, 8'hFE, 1'b1, 1'b0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; taken = 1'b0; native = 1'b0;
        op_addr = '0; disp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_strobe();
        t_not_taken();
        t_targets();
        t_cross();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule